// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block forms the word returned when the host reads the bank that is busy with an automatic program or erase. While the operation runs, the read data carries status flags in place of array contents:
- a data-polling bit,
- a bit that alternates on every read,
- a time-limit fault bit,
- an erase-window bit.

Once the operation finishes, reads return the normal array data again.

The flags are built from several inputs:
- A start pulse, which carries the operation kind.
- The value being programmed.
- A completion pulse.
- A fault input from the operation timer.
- A microsecond tick.
- A strobe that marks each accepted read.

For an erase, the block also times the hold window that precedes the real erase. While this window is open, further block addresses may still be queued, and each one written during the window restarts it. The block drives `erase_hold` high for as long as the window is open.

Top module: `osf_status_gen`

## Requirements
- R1: After reset, and whenever no operation is running, `busy` is 0 and `rd_data` equals `array_data`.
- R2: While a program is running, `rd_data[7]` is the complement of bit 7 of the `prog_data` value captured with `op_start`.
- R3: While an erase is running, `rd_data[7]` is 0.
- R4: While busy, `rd_data[6]` inverts after every read strobe. A read with `rd_strobe` low does not change it. After `op_done`, reads return `array_data` and no further inversion takes place.
- R5: A `timeout_fault` pulse while busy makes `rd_data[5]` read 1. It stays 1 until `op_done`, reset or the next `op_start`.
- R6: After an erase start, `rd_data[3]` reads 0 and `erase_hold` is 1 for exactly HOLD_US `us_tick` pulses. After that, `rd_data[3]` reads 1 and `erase_hold` is 0 until the erase ends.
- R7: A `blk_addr_wr` pulse while the hold window is open restarts the full HOLD_US count. The same pulse after the window has closed has no effect.
- R8: While busy, bits 4, 2, 1 and 0 of `rd_data` read 0. During a program, bit 3 also reads 0.
- R9: Asserting reset clears the busy state, the alternating bit (it reads 0 on the first status read after reset) and the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| op_start | input | 1 | One-cycle pulse starting an operation (taken only when idle) |
| op_erase | input | 1 | Kind at start: 1 erase, 0 program |
| prog_data | input | DATA_W | Value being programmed, captured at start |
| op_done | input | 1 | One-cycle pulse ending the operation |
| timeout_fault | input | 1 | Operation exceeded its time limit |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| blk_addr_wr | input | 1 | Further valid block address written |
| rd_strobe | input | 1 | One-cycle pulse per read of the bank |
| array_data | input | DATA_W | Normal array read data |
| rd_data | output | DATA_W | Read data returned to the host |
| busy | output | 1 | Operation in progress |
| erase_hold | output | 1 | Erase hold window open |

## Verification
The assertions assume the following about the inputs:
- `op_done` and `op_start` never arrive in the same cycle.
- `op_start` comes only while the block is idle.
- `op_done` is never pulsed while the block is idle.

The directed tasks keep to these rules by pulsing each control input for one cycle, starting an operation only after the previous one has been closed, and ending every operation with a single `op_done`. Ticks are spaced several cycles apart, so a block write and a tick never coincide.

// File: rtl/osf_pkg.sv
package osf_pkg;
   typedef enum logic [1:0] {
      OPK_IDLE  = 2'd0,
      OPK_PROG  = 2'd1,
      OPK_ERASE = 2'd2
   } op_kind_t;

   localparam int POLL_POS  = 7;
   localparam int TOG_POS   = 6;
   localparam int FAULT_POS = 5;
   localparam int WIN_POS   = 3;
endpackage

// File: rtl/osf_op_track.sv
module osf_op_track
   import osf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_erase,
   input  logic [DATA_W-1:0] prog_data,
   input  logic              op_done,
   input  logic              timeout_fault,
   input  logic              rd_strobe,
   output op_kind_t          kind,
   output logic              poll_bit,
   output logic              tog_bit,
   output logic              fault_bit
);
   logic accept;
   logic is_busy;

   assign is_busy = (kind != OPK_IDLE);
   assign accept  = op_start && !is_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind     <= OPK_IDLE;
         poll_bit <= 1'b0;
      end else if (accept) begin
         kind     <= op_erase ? OPK_ERASE : OPK_PROG;
         poll_bit <= op_erase ? 1'b0 : ~prog_data[POLL_POS];
      end else if (op_done) begin
         kind     <= OPK_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_bit <= 1'b0;
      end else if (rd_strobe && is_busy) begin
         tog_bit <= ~tog_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_bit <= 1'b0;
      end else if (accept || op_done) begin
         fault_bit <= 1'b0;
      end else if (timeout_fault && is_busy) begin
         fault_bit <= 1'b1;
      end
   end

   AST_TOG_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_bit != $past(tog_bit)) |-> $past(rd_strobe && is_busy)); // R4
   AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_bit && !op_done && !op_start) |=> fault_bit); // R5
   AST_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && !op_start) |=> (kind == OPK_IDLE)); // R1
endmodule

// File: rtl/osf_hold_timer.sv
module osf_hold_timer #(
   parameter int HOLD_US        = 50,
   parameter bit RESTART_ON_BLK = 1'b1,
   localparam int CNT_W         = $clog2(HOLD_US + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic cancel,
   input  logic us_tick,
   input  logic blk_addr_wr,
   output logic window_open
);
   logic [CNT_W-1:0] remain;
   logic             restart;

   generate
      if (RESTART_ON_BLK) begin : g_restart
         assign restart = blk_addr_wr && window_open;
      end else begin : g_fixed
         assign restart = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain      <= '0;
         window_open <= 1'b0;
      end else if (cancel) begin
         remain      <= '0;
         window_open <= 1'b0;
      end else if (arm || restart) begin
         remain      <= CNT_W'(HOLD_US);
         window_open <= 1'b1;
      end else if (us_tick && window_open) begin
         remain      <= remain - 1'b1;
         window_open <= (remain != CNT_W'(1));
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= CNT_W'(HOLD_US)); // R6
   AST_CLOSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !window_open |-> (remain == '0)); // R6
   AST_NO_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!window_open && !arm) |=> !window_open); // R7
endmodule

// File: rtl/osf_read_mux.sv
module osf_read_mux
   import osf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  op_kind_t          kind,
   input  logic              poll_bit,
   input  logic              tog_bit,
   input  logic              fault_bit,
   input  logic              window_open,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data
);
   always_comb begin
      if (kind == OPK_IDLE) begin
         rd_data = array_data;
      end else begin
         rd_data            = '0;
         rd_data[POLL_POS]  = poll_bit;
         rd_data[TOG_POS]   = tog_bit;
         rd_data[FAULT_POS] = fault_bit;
         rd_data[WIN_POS]   = (kind == OPK_ERASE) && !window_open;
      end
   end
endmodule

// File: rtl/osf_status_gen.sv
module osf_status_gen
   import osf_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int HOLD_US        = 50,
   parameter bit RESTART_ON_BLK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_erase,
   input  logic [DATA_W-1:0] prog_data,
   input  logic              op_done,
   input  logic              timeout_fault,
   input  logic              us_tick,
   input  logic              blk_addr_wr,
   input  logic              rd_strobe,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              erase_hold
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("osf_status_gen: DATA_W must be at least 8");
      end
      if (HOLD_US < 1) begin : g_bad_hold
         $error("osf_status_gen: HOLD_US must be at least 1");
      end
   endgenerate

   op_kind_t kind;
   logic     poll_bit;
   logic     tog_bit;
   logic     fault_bit;
   logic     window_open;

   osf_op_track #(.DATA_W(DATA_W)) i_track (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
      .prog_data(prog_data), .op_done(op_done), .timeout_fault(timeout_fault),
      .rd_strobe(rd_strobe), .kind(kind), .poll_bit(poll_bit),
      .tog_bit(tog_bit), .fault_bit(fault_bit)
   );

   osf_hold_timer #(.HOLD_US(HOLD_US), .RESTART_ON_BLK(RESTART_ON_BLK)) i_hold (
      .clk(clk), .rst_n(rst_n),
      .arm(op_start && op_erase && (kind == OPK_IDLE)),
      .cancel(op_done), .us_tick(us_tick), .blk_addr_wr(blk_addr_wr),
      .window_open(window_open)
   );

   osf_read_mux #(.DATA_W(DATA_W)) i_mux (
      .kind(kind), .poll_bit(poll_bit), .tog_bit(tog_bit),
      .fault_bit(fault_bit), .window_open(window_open),
      .array_data(array_data), .rd_data(rd_data)
   );

   assign busy       = (kind != OPK_IDLE);
   assign erase_hold = window_open;

   AST_HOLD_ONLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_hold |-> (kind == OPK_ERASE)); // R6
   AST_IDLE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (rd_data == array_data)); // R1
   AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == OPK_ERASE) |-> !rd_data[POLL_POS]); // R3
   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rd_data[4] == 1'b0 && rd_data[2:0] == 3'b000)); // R8
endmodule

// File: tb/test_osf_status_gen.sv
module test_osf_status_gen;
   localparam int DW   = 8;
   localparam int HOLD = 50;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_start = 0, op_erase = 0, op_done = 0, timeout_fault = 0;
   logic          us_tick = 0, blk_addr_wr = 0, rd_strobe = 0;
   logic [DW-1:0] prog_data = '0, array_data = 8'h5A;
   logic [DW-1:0] rd_data;
   logic          busy, erase_hold;

   int errors = 0;
   int checks = 0;
   logic exp_tog = 1'b0;

   always #2.5 clk = ~clk;

   osf_status_gen #(.DATA_W(DW), .HOLD_US(HOLD)) i_osf_status_gen (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
      .prog_data(prog_data), .op_done(op_done), .timeout_fault(timeout_fault),
      .us_tick(us_tick), .blk_addr_wr(blk_addr_wr), .rd_strobe(rd_strobe),
      .array_data(array_data), .rd_data(rd_data), .busy(busy),
      .erase_hold(erase_hold)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         pulse(us_tick); step(); step();
      end
   endtask

   // status read: sample with strobe high, inversion lands at the edge
   task automatic do_read(output logic [DW-1:0] val);
      @(negedge clk); rd_strobe = 1'b1; #1 val = rd_data;
      @(negedge clk); rd_strobe = 1'b0;
      if (busy) exp_tog = ~exp_tog;
   endtask

   task automatic start_op(input logic er, input logic [DW-1:0] pd);
      @(negedge clk); op_start = 1'b1; op_erase = er; prog_data = pd;
      @(negedge clk); op_start = 1'b0;
   endtask

   task automatic t_reset_state();
      chk("R1 idle busy", busy, 0);
      #1 chk("R1 idle passthrough", rd_data, array_data);
      array_data = 8'hC3; #1 chk("R1 idle passthrough 2", rd_data, 8'hC3);
   endtask

   task automatic t_program();
      logic [DW-1:0] v;
      start_op(1'b0, 8'h80);
      chk("R2 busy", busy, 1);
      do_read(v);
      chk("R2 poll bit ~1", v[7], 0);
      chk("R8 spare bits", {v[4], v[3], v[2:0]}, 0);
      chk("R4 first toggle", v[6], 0);
      do_read(v);
      chk("R4 second toggle", v[6], 1);
      step(); step();
      #1 chk("R4 no strobe no change", rd_data[6], exp_tog);
      pulse(op_done);
      array_data = 8'h80;
      #1 chk("R1 after done true data", rd_data, 8'h80);
      do_read(v); do_read(v);
      chk("R4 frozen after done", v, 8'h80);
      start_op(1'b0, 8'h11);
      do_read(v);
      chk("R2 poll bit ~0", v[7], 1);
      chk("R4 toggle continues", v[6], 0);
      pulse(op_done);
   endtask

   task automatic t_timeout();
      logic [DW-1:0] v;
      start_op(1'b0, 8'h00);
      do_read(v);
      chk("R5 no fault yet", v[5], 0);
      pulse(timeout_fault);
      do_read(v);
      chk("R5 fault set", v[5], 1);
      do_read(v);
      chk("R5 fault held", v[5], 1);
      pulse(op_done);
      start_op(1'b1, 8'h00);
      #1 chk("R5 cleared on new op", rd_data[5], 0);
      pulse(op_done);
   endtask

   task automatic t_erase_window();
      logic [DW-1:0] v;
      start_op(1'b1, 8'hFF);
      chk("R6 hold open at start", erase_hold, 1);
      do_read(v);
      chk("R3 erase poll bit", v[7], 0);
      chk("R6 window bit low", v[3], 0);
      ticks(HOLD - 1);
      #1 chk("R6 still open at N-1", {erase_hold, rd_data[3]}, 2'b10);
      ticks(1);
      #1 chk("R6 closed at N", {erase_hold, rd_data[3]}, 2'b01);
      pulse(blk_addr_wr);
      #1 chk("R7 late block write ignored", {erase_hold, rd_data[3]}, 2'b01);
      do_read(v);
      chk("R3 poll bit after window", v[7], 0);
      pulse(op_done);
      #1 chk("R1 erase done passthrough", rd_data, array_data);
   endtask

   task automatic t_restart();
      start_op(1'b1, 8'h00);
      ticks(30);
      pulse(blk_addr_wr);
      ticks(HOLD - 1);
      #1 chk("R7 restarted window open", erase_hold, 1);
      ticks(1);
      #1 chk("R7 restarted window closed", erase_hold, 0);
      pulse(op_done);
   endtask

   task automatic t_hw_reset();
      logic [DW-1:0] v;
      start_op(1'b0, 8'h00);
      do_read(v);
      pulse(timeout_fault);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      exp_tog = 1'b0;
      chk("R9 busy cleared", busy, 0);
      start_op(1'b0, 8'h00);
      do_read(v);
      chk("R9 toggle cleared", v[6], 0);
      chk("R9 fault cleared", v[5], 0);
      pulse(op_done);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset_state();
      t_program();
      t_timeout();
      t_erase_window();
      t_restart();
      t_hw_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule